// File: doc/BRIEF.md
# Block-Transfer DMA Controller

This controller copies a run of consecutive memory words to a peripheral, or fills a run of memory words from a peripheral, so the processor does not have to. Software programs a first word address, a word count and a direction through a small four-slot register port. It then writes the start bit. From that point the controller competes for the shared system bus like any other master. It touches memory only while it holds the bus. It passes each word across a request/acknowledge handshake on the peripheral side.

When the last word has moved, the controller gives the bus back with a one-cycle release pulse. It then raises a level interrupt, which stays up until software acknowledges it. An arbiter may withdraw the grant in the middle of a block. The word in flight is always completed first. The controller then releases the bus, asks for it again, and carries on at the next address.

The register port uses a 2-bit slot select: slot 0 is the address, slot 1 the count, slot 2 control and slot 3 status. Reads are combinational on the same select lines. Memory is a synchronous port with one cycle of read latency.

Top module: `dma_block_mover`

## Requirements
- R1: Writes to slot 0 (address) and slot 1 (count) while idle load those values, and reading the same slot returns them. In slot 2, bit 1 selects the direction (0 = memory to peripheral, 1 = peripheral to memory) and bit 0 is the start command.
- R2: Programming the address and count causes no bus request, memory strobe or peripheral request. A start with a nonzero count raises `bus_req` in the cycle after the start write.
- R3: `mem_rd` and `mem_wr` are only ever high while `bus_req` is high, and a word is only begun in a cycle where `bus_gnt` is high.
- R4: In direction 0, each word is read from `mem_addr` and then offered on `dev_wdata` with `dev_req` held steady until `dev_ack`. Words reach the peripheral in ascending address order, one handshake per word.
- R5: In direction 1, `dev_req` is held until `dev_ack`. The value on `dev_rdata` in the acknowledge cycle is written to memory on the next cycle at the current address.
- R6: Each completed word advances the address by one and lowers the count by one. At the end, the address reads back as start plus count and the count reads back as zero.
- R7: After the final word, `bus_req` falls and `bus_rel` is high for exactly one cycle, with `bus_req` low during that cycle.
- R8: Status slot 3 reads bit 0 = busy and bit 1 = done. Busy is set from the cycle after the start write until completion. Done and `irq` rise in the cycle after the final release pulse. An accepted start clears done and `irq`.
- R9: `irq` stays high until a status write with bit 1 set. Other register writes leave it high.
- R10: A start with a zero count sets done and `irq` in the cycle after the start write and never requests the bus.
- R11: If the grant is low when a word finishes, the controller pulses `bus_rel`, requests again and resumes at the next address. No word is lost or repeated, so a block with one withdrawal shows two release pulses.
- R12: While busy, writes to the address, count and control slots are ignored. The block finishes with the address and count it started with.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cpu_we | input | 1 | Register write strobe |
| cpu_sel | input | 2 | Register slot select (0 addr, 1 count, 2 control, 3 status) |
| cpu_wdata | input | CPU_W | Register write data |
| cpu_rdata | output | CPU_W | Register read data for the selected slot |
| irq | output | 1 | Completion interrupt, level |
| bus_req | output | 1 | Bus ownership request |
| bus_gnt | input | 1 | Bus grant from the arbiter |
| bus_rel | output | 1 | One-cycle bus release pulse |
| mem_addr | output | ADDR_W | Memory word address |
| mem_rd | output | 1 | Memory read strobe |
| mem_wr | output | 1 | Memory write strobe |
| mem_wdata | output | DATA_W | Memory write data |
| mem_rdata | input | DATA_W | Memory read data, valid one cycle after `mem_rd` |
| dev_req | output | 1 | Peripheral transfer request |
| dev_ack | input | 1 | Peripheral acknowledge |
| dev_wdata | output | DATA_W | Word offered to the peripheral |
| dev_rdata | input | DATA_W | Word supplied by the peripheral |

## Verification
A start write lands on one clock edge. The bench therefore samples one falling edge later, where `bus_req`, the busy bit and, for a zero count, `irq` must already hold their new values. Register writes likewise take effect at the edge they straddle and are read back at the following falling edge. A word in direction 0 costs at least three cycles (read, capture, handshake), and one in direction 1 at least two (handshake, write). Since the length of the peripheral wait varies, the bench waits on `irq` with a bounded loop instead of counting fixed cycles. It times the release by monitor: `irq` must rise exactly one cycle after the last `bus_rel`, and the number of release pulses is checked per block.

// File: rtl/dma_mover_pkg.sv
// Shared encodings for the block-transfer DMA controller.
// Assumes a 2-bit register slot select on the CPU side.
package dma_mover_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,   // waiting for a start command
        ST_REQ,    // bus requested, waiting for grant
        ST_MRD,    // memory read strobe
        ST_MCAP,   // capture memory read data
        ST_DHS,    // peripheral handshake
        ST_MWR,    // memory write strobe
        ST_REL     // one-cycle bus release
    } dma_state_e;

    localparam logic DIR_M2D = 1'b0;
    localparam logic DIR_D2M = 1'b1;

    localparam logic [1:0] SEL_ADDR = 2'd0;
    localparam logic [1:0] SEL_CNT  = 2'd1;
    localparam logic [1:0] SEL_CTRL = 2'd2;
    localparam logic [1:0] SEL_STAT = 2'd3;

    localparam int CTRL_START_BIT = 0;
    localparam int CTRL_DIR_BIT   = 1;
    localparam int STAT_BUSY_BIT  = 0;
    localparam int STAT_DONE_BIT  = 1;

endpackage

// File: rtl/dma_mover_regs.sv
// CPU-visible register file: working address and count, direction, done flag.
// The address and count registers are the live transfer counters, stepped by
// the engine. Assumes ADDR_W and CNT_W do not exceed CPU_W.
module dma_mover_regs
    import dma_mover_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int CNT_W  = 16,
    parameter int CPU_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpu_we,
    input  logic [1:0]        cpu_sel,
    input  logic [CPU_W-1:0]  cpu_wdata,
    output logic [CPU_W-1:0]  cpu_rdata,
    input  logic              busy,
    input  logic              step,
    input  logic              finish,
    output logic [ADDR_W-1:0] cur_addr,
    output logic              cnt_zero,
    output logic              cnt_last,
    output logic              dir,
    output logic              go,
    output logic              irq
);

    logic [ADDR_W-1:0] addr_q;
    logic [CNT_W-1:0]  cnt_q;
    logic              dir_q;
    logic              done_q;
    logic              wr_addr, wr_cnt, wr_ctrl, clr_done;

    // Decode the register writes; setup writes count only while idle.
    always_comb begin
        wr_addr  = cpu_we && (cpu_sel == SEL_ADDR) && !busy;
        wr_cnt   = cpu_we && (cpu_sel == SEL_CNT)  && !busy;
        wr_ctrl  = cpu_we && (cpu_sel == SEL_CTRL) && !busy;
        clr_done = cpu_we && (cpu_sel == SEL_STAT) && cpu_wdata[STAT_DONE_BIT];
        go       = wr_ctrl && cpu_wdata[CTRL_START_BIT];
    end

    // Address and count: loaded by software, stepped once per finished word.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q <= '0;
            cnt_q  <= '0;
        end else begin
            if (wr_addr)   addr_q <= cpu_wdata[ADDR_W-1:0];
            else if (step) addr_q <= addr_q + ADDR_W'(1);
            if (wr_cnt)    cnt_q  <= cpu_wdata[CNT_W-1:0];
            else if (step) cnt_q  <= cnt_q - CNT_W'(1);
        end
    end

    // Direction latch and done/interrupt flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dir_q  <= DIR_M2D;
            done_q <= 1'b0;
        end else begin
            if (wr_ctrl) dir_q <= cpu_wdata[CTRL_DIR_BIT];
            if (finish)        done_q <= 1'b1;
            else if (go)       done_q <= 1'b0;
            else if (clr_done) done_q <= 1'b0;
        end
    end

    // Combinational readback of the selected slot.
    always_comb begin
        case (cpu_sel)
            SEL_ADDR: cpu_rdata = CPU_W'(addr_q);
            SEL_CNT:  cpu_rdata = CPU_W'(cnt_q);
            SEL_CTRL: cpu_rdata = CPU_W'({dir_q, 1'b0});
            default:  cpu_rdata = CPU_W'({done_q, busy});
        endcase
    end

    assign cur_addr = addr_q;
    assign cnt_zero = (cnt_q == '0);
    assign cnt_last = (cnt_q == CNT_W'(1));
    assign dir      = dir_q;
    assign irq      = done_q;

    p_count_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
        step |=> cnt_q == $past(cnt_q) - CNT_W'(1));

    p_irq_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && !clr_done && !go) |=> irq);

    p_zero_count_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (go && cnt_zero) |=> (irq && !busy));

    p_busy_write_ignored_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && cpu_we && cpu_sel == SEL_ADDR && !step) |=> addr_q == $past(addr_q));

endmodule

// File: rtl/dma_mover_engine.sv
// Transfer sequencer: bus request/grant/release, memory strobes and the
// peripheral request/acknowledge handshake. One data register serves both
// directions. Grant is examined only at word boundaries; a started word
// always completes. Assumes memory read data is valid one cycle after mem_rd.
module dma_mover_engine
    import dma_mover_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              go,
    input  logic              cnt_zero,
    input  logic              cnt_last,
    input  logic              dir,
    input  logic              bus_gnt,
    output logic              bus_req,
    output logic              bus_rel,
    output logic              mem_rd,
    output logic              mem_wr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic              dev_req,
    input  logic              dev_ack,
    output logic [DATA_W-1:0] dev_wdata,
    input  logic [DATA_W-1:0] dev_rdata,
    output logic              busy,
    output logic              step,
    output logic              finish
);

    dma_state_e        state_q, state_d;
    logic [DATA_W-1:0] data_q;
    dma_state_e        first_st;

    // Next state, word-completion and finish decode.
    always_comb begin
        first_st = (dir == DIR_D2M) ? ST_DHS : ST_MRD;
        step     = 1'b0;
        finish   = 1'b0;
        state_d  = state_q;
        case (state_q)
            ST_IDLE: if (go) begin
                if (cnt_zero) finish  = 1'b1;
                else          state_d = ST_REQ;
            end
            ST_REQ:  if (bus_gnt) state_d = first_st;
            ST_MRD:  state_d = ST_MCAP;
            ST_MCAP: state_d = ST_DHS;
            ST_DHS:  if (dev_ack) begin
                if (dir == DIR_D2M) state_d = ST_MWR;
                else                step    = 1'b1;
            end
            ST_MWR:  step = 1'b1;
            ST_REL: begin
                finish  = cnt_zero;
                state_d = cnt_zero ? ST_IDLE : ST_REQ;
            end
            default: state_d = ST_IDLE;
        endcase
        if (step) state_d = (cnt_last || !bus_gnt) ? ST_REL : first_st;
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Word holding register, filled from memory or from the peripheral.
    always_ff @(posedge clk) begin
        if (!rst_n)                                             data_q <= '0;
        else if (state_q == ST_MCAP)                            data_q <= mem_rdata;
        else if (state_q == ST_DHS && dev_ack && dir == DIR_D2M) data_q <= dev_rdata;
    end

    // Output decode from the state.
    always_comb begin
        busy      = (state_q != ST_IDLE);
        bus_rel   = (state_q == ST_REL);
        bus_req   = busy && !bus_rel;
        mem_rd    = (state_q == ST_MRD);
        mem_wr    = (state_q == ST_MWR);
        dev_req   = (state_q == ST_DHS);
        mem_wdata = data_q;
        dev_wdata = data_q;
    end

    p_strobe_owns_bus_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rd || mem_wr) |-> bus_req);

    p_word_needs_grant_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_REQ && !bus_gnt) |=> state_q == ST_REQ);

    p_no_idle_request_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !go) |=> !bus_req);

    p_handshake_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (dev_req && !dev_ack) |=> (dev_req && $stable(dev_wdata)));

    p_rel_without_req_r7: assert property (@(posedge clk) disable iff (!rst_n)
        bus_rel |-> !bus_req);

    p_rel_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
        bus_rel |=> !bus_rel);

endmodule

// File: rtl/dma_block_mover.sv
// Top level of the block-transfer DMA controller: register file plus engine.
// Assumes a central arbiter that answers bus_req with bus_gnt and honours
// bus_rel, a synchronous memory and a request/acknowledge peripheral.
module dma_block_mover #(
    parameter int ADDR_W = 16,
    parameter int CNT_W  = 16,
    parameter int DATA_W = 16,
    parameter int CPU_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpu_we,
    input  logic [1:0]        cpu_sel,
    input  logic [CPU_W-1:0]  cpu_wdata,
    output logic [CPU_W-1:0]  cpu_rdata,
    output logic              irq,
    output logic              bus_req,
    input  logic              bus_gnt,
    output logic              bus_rel,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_rd,
    output logic              mem_wr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic              dev_req,
    input  logic              dev_ack,
    output logic [DATA_W-1:0] dev_wdata,
    input  logic [DATA_W-1:0] dev_rdata
);

    logic busy, step, finish, cnt_zero, cnt_last, dir, go;

    dma_mover_regs #(
        .ADDR_W (ADDR_W),
        .CNT_W  (CNT_W),
        .CPU_W  (CPU_W)
    ) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .cpu_we    (cpu_we),
        .cpu_sel   (cpu_sel),
        .cpu_wdata (cpu_wdata),
        .cpu_rdata (cpu_rdata),
        .busy      (busy),
        .step      (step),
        .finish    (finish),
        .cur_addr  (mem_addr),
        .cnt_zero  (cnt_zero),
        .cnt_last  (cnt_last),
        .dir       (dir),
        .go        (go),
        .irq       (irq)
    );

    dma_mover_engine #(
        .DATA_W (DATA_W)
    ) u_engine (
        .clk       (clk),
        .rst_n     (rst_n),
        .go        (go),
        .cnt_zero  (cnt_zero),
        .cnt_last  (cnt_last),
        .dir       (dir),
        .bus_gnt   (bus_gnt),
        .bus_req   (bus_req),
        .bus_rel   (bus_rel),
        .mem_rd    (mem_rd),
        .mem_wr    (mem_wr),
        .mem_wdata (mem_wdata),
        .mem_rdata (mem_rdata),
        .dev_req   (dev_req),
        .dev_ack   (dev_ack),
        .dev_wdata (dev_wdata),
        .dev_rdata (dev_rdata),
        .busy      (busy),
        .step      (step),
        .finish    (finish)
    );

endmodule

// File: tb/dma_block_mover_bench.sv
`timescale 1ns/1ps
// Self-checking bench: vector table of block transfers, then directed tests.
module dma_block_mover_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cpu_we = 1'b0;
    logic [1:0]  cpu_sel = 2'd0;
    logic [15:0] cpu_wdata = '0;
    logic [15:0] cpu_rdata;
    logic        irq, bus_req, bus_gnt, bus_rel, mem_rd, mem_wr, dev_req, dev_ack;
    logic [15:0] mem_addr, mem_wdata, mem_rdata, dev_wdata, dev_rdata;

    int tests = 0;
    int fails = 0;

    always #2.5 clk = ~clk;

    dma_block_mover u_dma_block_mover (
        .clk(clk), .rst_n(rst_n), .cpu_we(cpu_we), .cpu_sel(cpu_sel),
        .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata), .irq(irq),
        .bus_req(bus_req), .bus_gnt(bus_gnt), .bus_rel(bus_rel),
        .mem_addr(mem_addr), .mem_rd(mem_rd), .mem_wr(mem_wr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .dev_req(dev_req),
        .dev_ack(dev_ack), .dev_wdata(dev_wdata), .dev_rdata(dev_rdata)
    );

    // ---------------- models ----------------
    logic        clr_log = 1'b0;
    logic [3:0]  ack_delay = 4'd0;
    logic        preempt = 1'b0;
    logic [15:0] mem_m [0:511];
    logic [15:0] sink [0:15];
    logic [3:0]  dev_wait;
    int          dev_n;
    int          hold;

    // Synchronous memory with one cycle of read latency.
    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 512; i++) mem_m[i] <= 16'h5000 + 16'(i);
            mem_rdata <= '0;
        end else begin
            if (mem_wr) mem_m[mem_addr[8:0]] <= mem_wdata;
            if (mem_rd) mem_rdata <= mem_m[mem_addr[8:0]];
        end
    end

    // Peripheral: acknowledges after ack_delay cycles, logs words it receives.
    always @(posedge clk) begin
        if (!rst_n || clr_log) begin
            dev_ack <= 1'b0; dev_wait <= '0; dev_n <= 0;
        end else if (dev_req && dev_ack) begin
            sink[dev_n[3:0]] <= dev_wdata;
            dev_n <= dev_n + 1; dev_ack <= 1'b0; dev_wait <= '0;
        end else if (dev_req) begin
            if (dev_wait >= ack_delay) dev_ack <= 1'b1;
            else dev_wait <= dev_wait + 4'd1;
        end
    end
    assign dev_rdata = 16'hA000 + 16'(dev_n);

    // Arbiter: grants a request; in preempt mode withdraws grant during word 2.
    always @(posedge clk) begin
        if (!rst_n || clr_log) begin
            bus_gnt <= 1'b0; hold <= 0;
        end else begin
            if (preempt && dev_req && !dev_ack && dev_wait == 4'd0 && dev_n == 1) hold <= 6;
            else if (hold > 0) hold <= hold - 1;
            bus_gnt <= bus_req && (hold == 0);
        end
    end

    // Monitor: protocol violations, release count, request cycles.
    int   viol, rel_cnt, req_cyc, cyc, last_rel_cyc;
    logic irq_prev;
    always @(negedge clk) begin
        if (!rst_n || clr_log) begin
            viol <= 0; rel_cnt <= 0; req_cyc <= 0; cyc <= 0; last_rel_cyc <= 0;
            irq_prev <= irq;
        end else begin
            cyc <= cyc + 1;
            irq_prev <= irq;
            if ((mem_rd || mem_wr) && !bus_req) viol <= viol + 1;   // R3
            if (bus_rel && bus_req) viol <= viol + 1;               // R7
            if (bus_rel) begin rel_cnt <= rel_cnt + 1; last_rel_cyc <= cyc; end
            if (bus_req) req_cyc <= req_cyc + 1;
            if (irq && !irq_prev && rel_cnt > 0 && cyc - last_rel_cyc != 1)
                viol <= viol + 1;                                   // R8
        end
    end

    // ---------------- helpers ----------------
    task automatic check(input bit ok, input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic cpu_write(input logic [1:0] sel, input logic [15:0] val);
        @(negedge clk);
        cpu_we = 1'b1; cpu_sel = sel; cpu_wdata = val;
        @(negedge clk);
        cpu_we = 1'b0;
    endtask

    task automatic cpu_read(input logic [1:0] sel, output logic [15:0] val);
        cpu_sel = sel;
        #0.5;
        val = cpu_rdata;
    endtask

    task automatic wait_irq();
        for (int k = 0; k < 2000 && !irq; k++) @(negedge clk);
    endtask

    task automatic pulse_clr();
        @(negedge clk); clr_log = 1'b1;
        @(negedge clk); clr_log = 1'b0;
    endtask

    // dir[21] addr[20:13] count[12:5] ack_delay[4:1] preempt[0]
    localparam logic [21:0] VECS [0:5] = '{
        {1'b0, 8'h10, 8'd4, 4'd0, 1'b0},
        {1'b1, 8'h40, 8'd5, 4'd2, 1'b0},
        {1'b0, 8'h80, 8'd1, 4'd1, 1'b0},
        {1'b1, 8'h20, 8'd1, 4'd0, 1'b0},
        {1'b0, 8'h30, 8'd6, 4'd3, 1'b1},
        {1'b1, 8'h60, 8'd7, 4'd0, 1'b1}
    };

    // Watchdog: a hung run is one failed check.
    initial begin
        repeat (150000) @(posedge clk);
        tests++; fails++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    logic [15:0] rd;

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // Reset state (R1, R8)
        cpu_read(2'd0, rd); check(rd == 16'h0, "R1 reset address", 32'(rd), 32'h0);
        cpu_read(2'd1, rd); check(rd == 16'h0, "R1 reset count", 32'(rd), 32'h0);
        cpu_read(2'd3, rd); check(rd == 16'h0, "R8 reset status", 32'(rd), 32'h0);
        check(!irq && !bus_req && !dev_req, "R2 reset outputs idle",
              32'({irq, bus_req, dev_req}), 32'h0);

        // Vector table walk
        for (int v = 0; v < 6; v++) begin
            logic        vdir, vpre;
            logic [7:0]  vaddr, vcnt;
            {vdir, vaddr, vcnt, ack_delay, vpre} = VECS[v];
            preempt = vpre;
            pulse_clr();
            cpu_write(2'd0, 16'(vaddr));
            cpu_write(2'd1, 16'(vcnt));
            cpu_read(2'd0, rd); check(rd == 16'(vaddr), "R1 address readback", 32'(rd), 32'(vaddr));
            cpu_read(2'd1, rd); check(rd == 16'(vcnt), "R1 count readback", 32'(rd), 32'(vcnt));
            check(!bus_req && !dev_req && req_cyc == 0, "R2 no request before start",
                  32'(req_cyc), 32'h0);
            cpu_write(2'd2, {14'd0, vdir, 1'b1});
            check(bus_req, "R2 request after start", 32'(bus_req), 32'h1);
            cpu_read(2'd3, rd); check(rd[0] && !rd[1] && !irq, "R8 busy after start",
                  32'(rd), 32'h1);
            wait_irq();
            check(irq, "R8 irq at completion", 32'(irq), 32'h1);
            for (int k = 0; k < int'(vcnt); k++) begin
                if (vdir == 1'b0)
                    check(sink[k] == 16'h5000 + 16'(vaddr) + 16'(k), "R4 word to peripheral",
                          32'(sink[k]), 32'(16'h5000 + 16'(vaddr) + 16'(k)));
                else
                    check(mem_m[9'(vaddr) + 9'(k)] == 16'hA000 + 16'(k), "R5 word to memory",
                          32'(mem_m[9'(vaddr) + 9'(k)]), 32'(16'hA000 + 16'(k)));
            end
            check(dev_n == int'(vcnt), "R11 one handshake per word", 32'(dev_n), 32'(vcnt));
            cpu_read(2'd0, rd);
            check(rd == 16'(vaddr) + 16'(vcnt), "R6 final address", 32'(rd),
                  32'(16'(vaddr) + 16'(vcnt)));
            cpu_read(2'd1, rd); check(rd == 16'h0, "R6 final count", 32'(rd), 32'h0);
            check(rel_cnt == (vpre ? 2 : 1), "R7 R11 release pulses", 32'(rel_cnt),
                  32'(vpre ? 2 : 1));
            check(viol == 0, "R3 R7 R8 protocol monitor", 32'(viol), 32'h0);
            cpu_read(2'd3, rd); check(rd == 16'h2, "R8 done not busy", 32'(rd), 32'h2);
            cpu_write(2'd3, 16'h2);
            check(!irq, "R9 irq cleared by status write", 32'(irq), 32'h0);
        end

        // Zero count (R10)
        preempt = 1'b0;
        pulse_clr();
        cpu_write(2'd1, 16'h0);
        cpu_write(2'd2, 16'h1);
        check(irq, "R10 irq after zero-count start", 32'(irq), 32'h1);
        cpu_read(2'd3, rd); check(rd == 16'h2, "R10 done without busy", 32'(rd), 32'h2);
        repeat (4) @(negedge clk);
        check(req_cyc == 0 && rel_cnt == 0, "R10 bus never requested",
              32'(req_cyc), 32'h0);

        // Sticky interrupt (R9)
        cpu_write(2'd3, 16'h1);
        cpu_write(2'd0, 16'h0050);
        repeat (3) @(negedge clk);
        check(irq, "R9 irq held through other writes", 32'(irq), 32'h1);

        // Start clears done; writes while busy ignored (R8, R12)
        ack_delay = 4'd2;
        pulse_clr();
        cpu_write(2'd1, 16'd4);
        cpu_write(2'd2, 16'h1);
        check(!irq, "R8 start clears irq", 32'(irq), 32'h0);
        cpu_write(2'd0, 16'h01FF);
        cpu_write(2'd1, 16'd9);
        cpu_write(2'd2, 16'h3);
        cpu_read(2'd2, rd); check(rd == 16'h0, "R12 direction kept while busy", 32'(rd), 32'h0);
        wait_irq();
        cpu_read(2'd0, rd); check(rd == 16'h0054, "R12 address write ignored", 32'(rd), 32'h54);
        cpu_read(2'd1, rd); check(rd == 16'h0, "R12 count write ignored", 32'(rd), 32'h0);
        check(dev_n == 4 && sink[3] == 16'h5053, "R12 block unchanged",
              32'(sink[3]), 32'h5053);
        cpu_write(2'd3, 16'h2);

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule